// File: doc/BRIEF.md
# Serial Buffer Write Controller

This block sits behind a four-wire serial slave port and turns buffer-load commands into byte writes on two on-chip SRAM buffers of 512 bytes each. The serial pins (clock, active-low select, data in) are brought into the system clock domain through two-flop synchronizers. Every rising serial clock edge taken while select is low shifts in one bit, most significant bit first.

A command opens with an 8-bit opcode. 0x84 addresses buffer A and 0x87 addresses buffer B. Next comes a 24-bit address field: its upper 15 bits are ignored and its lower 9 bits give the location of the first data byte. Each complete data byte after that produces a one-cycle write strobe on the selected buffer's port. The location then advances by one and wraps from 511 back to 0. Writing goes on until select returns high. A byte that is only partly shifted in at that moment is dropped. The host may also raise a busy input. If busy is high when the opcode completes, the whole command is ignored, and so is any opcode that is not one of the two buffer-load opcodes.

Top module: `spi_buf_writer`

## Requirements
- R1: Opcode 0x84 directs the data bytes to the buffer A write port and opcode 0x87 directs them to the buffer B write port.
- R2: Bits are taken on rising serial clock edges while select is low, most significant bit first. The 8-bit opcode is followed by a 24-bit field whose upper 15 bits are ignored and whose lower 9 bits set the first write address.
- R3: Successive data bytes within one command are written at successive addresses, each one higher than the one before.
- R4: After a byte is written at address 511, the next byte goes to address 0 and writing continues.
- R5: Each complete data byte sent while select stays low gives exactly one write. No write happens once select is high, and a new select-low period must begin with a new opcode.
- R6: Data bits of an incomplete byte that are pending when select rises are discarded and cause no write.
- R7: An opcode other than 0x84 or 0x87 causes no write for the rest of that select-low period.
- R8: If busy is high when the eighth opcode bit is taken, the command causes no write.
- R9: During and after reset, with select high, both write strobes are low.
- R10: A write strobe is high for a single system clock cycle per byte, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Rejects a command whose opcode completes while high |
| spi_sck | input | 1 | Serial clock, asynchronous to clk |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| a_we | output | 1 | Buffer A write strobe |
| a_addr | output | 9 | Buffer A write address |
| a_wdata | output | 8 | Buffer A write data |
| b_we | output | 1 | Buffer B write strobe |
| b_addr | output | 9 | Buffer B write address |
| b_wdata | output | 8 | Buffer B write data |

## Verification
Some properties are checked on every clock cycle. Strobes are single-cycle and never overlap. No write follows a cycle in which synchronized select is high. Within one select-low period, each write lands one address above the previous one, modulo 512, which also covers the wrap. Other behaviour can only be shown by the bench's scenarios, because it depends on what was shifted in: the opcode-to-port mapping, the start address taken from the low 9 bits, the exact data values, the number of writes per command, the dropping of partial bytes, and the rejection of unknown opcodes and of commands issued while busy.

// File: rtl/spi_buf_writer.sv
module spi_buf_writer #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int OP_W = 8,
  parameter int PAD_BITS = 15,
  parameter logic [OP_W-1:0] OP_A = 8'h84,
  parameter logic [OP_W-1:0] OP_B = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              a_we,
  output logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_wdata,
  output logic              b_we,
  output logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_wdata
);
  localparam int FIELD_W = PAD_BITS + ADDR_W;
  localparam int CNT_W = $clog2(FIELD_W + 1);

  typedef enum logic [1:0] {PH_OP, PH_ADR, PH_DAT, PH_SKIP} phase_t;

  logic [1:0] sck_q, cs_q, si_q;
  logic sck_d;
  phase_t phase;
  logic [CNT_W-1:0] cnt;
  logic [FIELD_W-1:0] shreg;
  logic sel_b;
  logic [ADDR_W-1:0] ptr, waddr;
  logic [DATA_W-1:0] wdata;
  logic we_a, we_b;

  wire sck_rise = sck_q[1] & ~sck_d & ~cs_q[1];
  wire [FIELD_W-1:0] shift_nx = {shreg[FIELD_W-2:0], si_q[1]};
  wire [OP_W-1:0] op_nx = shift_nx[OP_W-1:0];
  wire op_ok = (op_nx == OP_A) || (op_nx == OP_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[0], spi_sck};
      cs_q  <= {cs_q[0], spi_cs_n};
      si_q  <= {si_q[0], spi_mosi};
      sck_d <= sck_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OP;
      cnt   <= '0;
      shreg <= '0;
      sel_b <= 1'b0;
      ptr   <= '0;
      waddr <= '0;
      wdata <= '0;
      we_a  <= 1'b0;
      we_b  <= 1'b0;
    end else begin
      we_a <= 1'b0;
      we_b <= 1'b0;
      if (cs_q[1]) begin
        phase <= PH_OP;
        cnt   <= '0;
      end else if (sck_rise) begin
        shreg <= shift_nx;
        cnt   <= cnt + 1'b1;
        case (phase)
          PH_OP: if (cnt == CNT_W'(OP_W - 1)) begin
            cnt <= '0;
            if (busy || !op_ok) phase <= PH_SKIP;
            else begin
              phase <= PH_ADR;
              sel_b <= (op_nx == OP_B);
            end
          end
          PH_ADR: if (cnt == CNT_W'(FIELD_W - 1)) begin
            cnt   <= '0;
            ptr   <= shift_nx[ADDR_W-1:0];
            phase <= PH_DAT;
          end
          PH_DAT: if (cnt == CNT_W'(DATA_W - 1)) begin
            cnt   <= '0;
            we_a  <= ~sel_b;
            we_b  <= sel_b;
            waddr <= ptr;
            wdata <= shift_nx[DATA_W-1:0];
            ptr   <= ptr + 1'b1;
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign a_we    = we_a;
  assign b_we    = we_b;
  assign a_addr  = waddr;
  assign b_addr  = waddr;
  assign a_wdata = wdata;
  assign b_wdata = wdata;
endmodule

// File: rtl/spi_buf_writer_chk.sv
module spi_buf_writer_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_sync,
  input logic              a_we,
  input logic              b_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [ADDR_W-1:0] b_addr
);
  logic have_prev;
  logic [ADDR_W-1:0] prev_addr;
  wire any_we = a_we | b_we;
  wire [ADDR_W-1:0] cur_addr = a_we ? a_addr : b_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (cs_sync) begin
      have_prev <= 1'b0;
    end else if (any_we) begin
      have_prev <= 1'b1;
      prev_addr <= cur_addr;
    end
  end

  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_we, b_we}));
  a_r10_a_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> !a_we);
  a_r10_b_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    b_we |=> !b_we);
  a_r5_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |-> !$past(cs_sync));
  a_r3_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (any_we && have_prev) |-> (cur_addr == ADDR_W'(prev_addr + 1'b1)));
endmodule

bind spi_buf_writer spi_buf_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_sync(cs_q[1]),
  .a_we(a_we), .b_we(b_we), .a_addr(a_addr), .b_addr(b_addr)
);

// File: tb/test_spi_buf_writer.sv
module test_spi_buf_writer;
  localparam int HALF = 4;
  logic clk = 1'b0, rst_n = 1'b0, busy = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic a_we, b_we;
  logic [8:0] a_addr, b_addr;
  logic [7:0] a_wdata, b_wdata;
  int checks = 0, errors = 0;
  int na = 0, nb = 0, overlap = 0, repeat_we = 0;
  logic pa = 1'b0, pb = 1'b0;
  logic [7:0] got_a [512], got_b [512], exp_a [512], exp_b [512];

  always #10 clk = ~clk;

  spi_buf_writer i_spi_buf_writer (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata)
  );

  always @(negedge clk) begin
    if (a_we) begin got_a[a_addr] = a_wdata; na++; end
    if (b_we) begin got_b[b_addr] = b_wdata; nb++; end
    if (a_we && b_we) overlap++;
    if ((a_we && pa) || (b_we && pb)) repeat_we++;
    pa = a_we;
    pb = b_we;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = -1;
    for (int i = 0; i < 512; i++)
      if (bad < 0 && (got_a[i] !== exp_a[i] || got_b[i] !== exp_b[i])) bad = i;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, (got_a[bad] << 8) | got_b[bad], (exp_a[bad] << 8) | exp_b[bad]);
  endtask

  task automatic txn(input logic [7:0] op, input logic [14:0] pad, input logic [8:0] start,
                     input int nbytes, input int partial, input logic bsy,
                     input string req);
    logic [8:0] p = start;
    logic valid = !bsy && (op == 8'h84 || op == 8'h87);
    int ea = 0, eb = 0;
    na = 0;
    nb = 0;
    busy = bsy;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send_bits({24'h0, op}, 8);
    send_bits({8'h0, pad, start}, 24);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] d = 8'($urandom);
      send_bits({24'h0, d}, 8);
      if (valid) begin
        if (op == 8'h84) begin exp_a[p] = d; ea++; end
        else begin exp_b[p] = d; eb++; end
        p = p + 9'd1;
      end
    end
    if (partial > 0) send_bits($urandom, partial);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    busy = 1'b0;
    check(na == ea, req, na, ea);
    check(nb == eb, req, nb, eb);
    compare_mem(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    for (int i = 0; i < 512; i++) begin
      got_a[i] = 8'h00; got_b[i] = 8'h00; exp_a[i] = 8'h00; exp_b[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    check(a_we == 1'b0 && b_we == 1'b0, "R9 during reset", int'({a_we, b_we}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(na == 0 && nb == 0, "R9 after reset", na + nb, 0);

    txn(8'h84, 15'h0000, 9'd3, 4, 0, 1'b0, "R1 buffer A");
    txn(8'h87, 15'h0000, 9'd3, 4, 0, 1'b0, "R1 buffer B");
    txn(8'h84, 15'h7fff, 9'd300, 3, 0, 1'b0, "R2 pad ignored");
    txn(8'h87, 15'h2a55, 9'd100, 16, 0, 1'b0, "R3 consecutive");
    txn(8'h84, 15'h0001, 9'd510, 5, 0, 1'b0, "R4 wrap A");
    txn(8'h87, 15'h0000, 9'd511, 3, 0, 1'b0, "R4 wrap B");
    txn(8'h84, 15'h0000, 9'd40, 2, 5, 1'b0, "R6 partial byte");
    txn(8'h87, 15'h0000, 9'd60, 0, 7, 1'b0, "R6 partial only");
    txn(8'h85, 15'h0000, 9'd80, 4, 0, 1'b0, "R7 bad opcode");
    txn(8'h04, 15'h0000, 9'd81, 3, 0, 1'b0, "R7 bad opcode 2");
    txn(8'h84, 15'h0000, 9'd90, 4, 0, 1'b1, "R8 busy A");
    txn(8'h87, 15'h0000, 9'd90, 4, 0, 1'b1, "R8 busy B");
    txn(8'h84, 15'h0000, 9'd200, 0, 0, 1'b0, "R5 no data");

    for (int r = 0; r < 30; r++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] op = (sel < 4) ? 8'h84 : (sel < 8) ? 8'h87 : 8'($urandom);
      txn(op, 15'($urandom), 9'($urandom), $urandom_range(0, 16),
          ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0,
          $urandom_range(0, 7) == 0, "R5 random");
    end

    check(overlap == 0, "R10 overlap", overlap, 0);
    check(repeat_we == 0, "R10 single cycle", repeat_we, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule